// File: doc/BRIEF.md
# Multi-Code Keypad Lock Controller

This block is the decision logic of a keyless door lock. It takes a stream of already-debounced key events, each a 4-bit matrix position, and checks them against three stored four-digit combinations. All three combinations share the same first three digits, so the last digit alone decides the outcome. The primary combination toggles the first lock and fires a timed momentary pulse. The secondary combination toggles the second lock. The duress combination toggles the first lock and latches an alarm. A key that breaks the expected sequence raises a timed tamper pulse and restarts entry. A half-entered combination is dropped without a tamper pulse when no key arrives within the entry window.

The user can replace all three combinations from the keypad. After the secondary combination, the program key is pressed twice. The next six accepted digits form the new set, and a clear key restarts that six-digit capture. While programming, the entry window does not apply.

Key events arrive on a valid/ready pair. The block never applies back-pressure: `key_ready` is high at all times, including during reset. Every cycle with `key_valid` high counts as exactly one key press. The key code is sampled on the rising clock edge that sees `key_valid` high, and all outputs change on that same edge.

Top module: `keylock_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `lock1`, `lock2`, `alarm`, `tamper`, `momentary` and `prog_mode` are low, `lock_status` is high and `key_ready` is high.
- R2: A key code is {column index, row index}, each 2 bits, counting from 0. After reset the shared head is 0x0, 0x1, 0x5. The last digit is 0x4 for primary, 0x0 for secondary and 0x1 for duress.
- R3: A complete primary combination toggles `lock1`, clears `alarm`, and drives `momentary` high for exactly PULSE_CYCLES cycles, starting the cycle after the fourth key.
- R4: A complete secondary combination toggles `lock2`. When the secondary and primary last digits are equal, that combination toggles `lock1` and `lock2` together.
- R5: A complete duress combination toggles `lock1` and sets `alarm`, which holds until the next primary combination. When the duress and primary last digits are equal, the combination acts only as primary and leaves `alarm` untouched.
- R6: Outside programming, a key that does not match the digit expected at the current position drives `tamper` high for PULSE_CYCLES cycles. The next key is then taken as the first digit.
- R7: If ENTRY_CYCLES or more cycles separate a key from the previous accepted key of an unfinished sequence, the sequence is silently dropped and that key is taken as a first digit. A gap of ENTRY_CYCLES-1 is still accepted.
- R8: A new trigger of `tamper` or `momentary` while it is high restarts its full PULSE_CYCLES width.
- R9: The program key 0xC, pressed twice right after a completed secondary combination, raises `prog_mode` on the edge of the second press. A 0xC anywhere else is an ordinary digit.
- R10: In programming, six non-clear keys d1..d6 set the primary to d1 d2 d3 d4, the secondary to d1 d2 d3 d5 and the duress to d1 d2 d3 d6. `prog_mode` falls on the sixth key. Programming has no time limit and does not touch the locks, `alarm` or `tamper`.
- R11: In programming, the clear key 0xE is not stored and restarts the capture at d1.
- R12: `lock_status` is always the inverse of `lock1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One key event this cycle |
| key_ready | output | 1 | Always high; the block accepts every key |
| key_code | input | 4 | {column index, row index} of the key |
| lock1 | output | 1 | Toggling lock output, primary and duress |
| lock2 | output | 1 | Toggling lock output, secondary |
| lock_status | output | 1 | Inverse of lock1, for an indicator |
| momentary | output | 1 | Timed pulse on a primary combination |
| tamper | output | 1 | Timed pulse on a wrong key |
| alarm | output | 1 | Latched on duress, cleared by primary |
| prog_mode | output | 1 | High while new combinations are captured |

## Verification
The bench times keys exactly at ENTRY_CYCLES-1 and ENTRY_CYCLES after the previous one. A timer off by one would accept a stale sequence or drop a live one, and one that fires tamper on expiry would show a pulse where none belongs. It reprograms the set so that the secondary last digit equals the primary last digit, which must toggle both locks. It also makes the duress last digit equal the primary last digit, where a careless comparator would raise the alarm on a plain unlock. It presses the clear key in the middle of a capture and a stray 0xC after a primary combination: the first would leave shifted combinations behind, and the second would wrongly open programming. Random key streams are weighted towards the digit expected next, so they regularly reach the deep states, and retriggered pulses show up as widths that end too early.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  localparam int KEY_W      = 4;
  localparam int CODE_LEN   = 4;
  localparam int HEAD_LEN   = CODE_LEN - 1;
  localparam int PROG_LEN   = CODE_LEN + 2;

  typedef logic [KEY_W-1:0] key_t;

  // Matrix position, 1-based column and row, to the key code {col-1, row-1}
  function automatic key_t key_at(input int col, input int row);
    logic [1:0] c;
    logic [1:0] r;
    c = 2'(col - 1);
    r = 2'(row - 1);
    return {c, r};
  endfunction

  localparam key_t KEY_PROG  = key_at(4, 1);
  localparam key_t KEY_CLEAR = key_at(4, 3);

  typedef enum logic [1:0] {
    MODE_ENTRY = 2'd0,
    MODE_ARM1  = 2'd1,
    MODE_ARM2  = 2'd2,
    MODE_PROG  = 2'd3
  } mode_e;

  typedef struct packed {
    key_t [HEAD_LEN-1:0] head;
    key_t                pri_last;
    key_t                sec_last;
    key_t                dur_last;
  } code_set_t;

  localparam code_set_t CODES_RESET = '{
    head:     {key_at(2, 2), key_at(1, 2), key_at(1, 1)},
    pri_last: key_at(2, 1),
    sec_last: key_at(1, 1),
    dur_last: key_at(1, 2)
  };

endpackage

// File: rtl/keylock_pulse.sv
module keylock_pulse #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (trig) begin
      cnt_q <= CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/keylock_timer.sv
module keylock_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic reload,
  output logic expire
);
  localparam int CW = $clog2(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= CW'(CYCLES - 1);
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run && (cnt_q == '0);

endmodule

// File: rtl/keylock_codes.sv
module keylock_codes
  import keylock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_valid,
  input  logic      cap_clear,
  input  key_t      cap_key,
  output logic      cap_last,
  output code_set_t codes
);
  localparam int CW = $clog2(PROG_LEN);
  localparam int LAST = PROG_LEN - 1;

  key_t          buf_q [LAST];
  logic [CW-1:0] cnt_q;
  code_set_t     codes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      codes_q <= CODES_RESET;
      for (int i = 0; i < LAST; i++) buf_q[i] <= '0;
    end else if (cap_valid) begin
      if (cap_clear) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(LAST)) begin
        cnt_q <= '0;
        for (int i = 0; i < HEAD_LEN; i++) codes_q.head[i] <= buf_q[i];
        codes_q.pri_last <= buf_q[CODE_LEN-1];
        codes_q.sec_last <= buf_q[CODE_LEN];
        codes_q.dur_last <= cap_key;
      end else begin
        buf_q[cnt_q] <= cap_key;
        cnt_q        <= cnt_q + 1'b1;
      end
    end
  end

  assign cap_last = (cnt_q == CW'(LAST));
  assign codes    = codes_q;

endmodule

// File: rtl/keylock_seq.sv
module keylock_seq
  import keylock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      key_valid,
  input  key_t      key,
  input  code_set_t codes,
  input  logic      expire,
  input  logic      cap_last,
  output logic      timer_run,
  output logic      timer_reload,
  output logic      cap_valid,
  output logic      cap_clear,
  output logic      hit_pri,
  output logic      hit_sec,
  output logic      hit_dur,
  output logic      miss,
  output logic      in_prog
);
  localparam int PW = $clog2(CODE_LEN);
  localparam logic [PW-1:0] LAST_POS = PW'(CODE_LEN - 1);

  mode_e         mode_q, mode_d, eff_mode;
  logic [PW-1:0] ptr_q, ptr_d, eff_ptr;
  logic          is_digit;
  logic          any_hit;

  always_comb begin
    eff_mode = mode_q;
    eff_ptr  = ptr_q;
    if (expire) begin
      eff_mode = MODE_ENTRY;
      eff_ptr  = '0;
    end
    mode_d       = eff_mode;
    ptr_d        = eff_ptr;
    timer_reload = 1'b0;
    cap_valid    = 1'b0;
    cap_clear    = 1'b0;
    hit_pri      = 1'b0;
    hit_sec      = 1'b0;
    hit_dur      = 1'b0;
    miss         = 1'b0;
    is_digit     = 1'b0;
    any_hit      = 1'b0;
    if (key_valid) begin
      unique case (eff_mode)
        MODE_PROG: begin
          cap_valid = 1'b1;
          cap_clear = (key == KEY_CLEAR);
          if (key != KEY_CLEAR && cap_last) mode_d = MODE_ENTRY;
        end
        MODE_ARM1: begin
          if (key == KEY_PROG) begin
            mode_d       = MODE_ARM2;
            timer_reload = 1'b1;
          end else begin
            is_digit = 1'b1;
          end
        end
        MODE_ARM2: begin
          if (key == KEY_PROG) mode_d = MODE_PROG;
          else                 is_digit = 1'b1;
        end
        default: is_digit = 1'b1;
      endcase

      if (is_digit) begin
        mode_d = MODE_ENTRY;
        if (eff_ptr != LAST_POS) begin
          if (key == codes.head[eff_ptr]) begin
            ptr_d        = eff_ptr + 1'b1;
            timer_reload = 1'b1;
          end else begin
            miss  = 1'b1;
            ptr_d = '0;
          end
        end else begin
          hit_pri = (key == codes.pri_last);
          hit_sec = (key == codes.sec_last);
          hit_dur = (key == codes.dur_last) && (codes.dur_last != codes.pri_last);
          any_hit = hit_pri | hit_sec | hit_dur;
          miss    = !any_hit;
          ptr_d   = '0;
          if (hit_sec) begin
            mode_d       = MODE_ARM1;
            timer_reload = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ENTRY;
      ptr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
    end
  end

  assign timer_run = (ptr_q != '0) || (mode_q == MODE_ARM1) || (mode_q == MODE_ARM2);
  assign in_prog   = (mode_q == MODE_PROG);

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int ENTRY_CYCLES = 20000,
  parameter int PULSE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  output logic       key_ready,
  input  logic [3:0] key_code,
  output logic       lock1,
  output logic       lock2,
  output logic       lock_status,
  output logic       momentary,
  output logic       tamper,
  output logic       alarm,
  output logic       prog_mode
);
  code_set_t codes;
  logic      expire, timer_run, timer_reload;
  logic      cap_valid, cap_clear, cap_last;
  logic      hit_pri, hit_sec, hit_dur, miss;
  logic      lock1_q, lock2_q, alarm_q;

  keylock_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_valid    (key_valid),
    .key          (key_code),
    .codes        (codes),
    .expire       (expire),
    .cap_last     (cap_last),
    .timer_run    (timer_run),
    .timer_reload (timer_reload),
    .cap_valid    (cap_valid),
    .cap_clear    (cap_clear),
    .hit_pri      (hit_pri),
    .hit_sec      (hit_sec),
    .hit_dur      (hit_dur),
    .miss         (miss),
    .in_prog      (prog_mode)
  );

  keylock_codes codes_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_valid (cap_valid),
    .cap_clear (cap_clear),
    .cap_key   (key_code),
    .cap_last  (cap_last),
    .codes     (codes)
  );

  keylock_timer #(.CYCLES(ENTRY_CYCLES)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .reload (timer_reload),
    .expire (expire)
  );

  keylock_pulse #(.CYCLES(PULSE_CYCLES)) mom_pulse_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (hit_pri),
    .active (momentary)
  );

  keylock_pulse #(.CYCLES(PULSE_CYCLES)) tamper_pulse_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (miss),
    .active (tamper)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      if (hit_pri || hit_dur) lock1_q <= !lock1_q;
      if (hit_sec)            lock2_q <= !lock2_q;
      if (hit_dur)            alarm_q <= 1'b1;
      else if (hit_pri)       alarm_q <= 1'b0;
    end
  end

  assign key_ready   = 1'b1;
  assign lock1       = lock1_q;
  assign lock2       = lock2_q;
  assign alarm       = alarm_q;
  assign lock_status = !lock1_q;

endmodule

// File: rtl/keylock_ctrl_chk.sv
module keylock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_valid,
  input logic [3:0] key_code,
  input logic       lock1,
  input logic       lock2,
  input logic       momentary,
  input logic       tamper,
  input logic       alarm,
  input logic       prog_mode
);

  // R3 R5: lock1 only moves on the edge of a key
  p_lock1_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock1) |-> $past(key_valid));

  // R5: alarm rises together with a lock1 toggle
  p_alarm_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (!$stable(lock1) && $past(key_valid)));

  // R3: alarm falls only with a primary unlock (lock1 toggle and momentary)
  p_alarm_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> (momentary && !$stable(lock1)));

  // R9: programming opens only on a program key
  p_prog_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> ($past(key_valid) && $past(key_code) == 4'hC));

  // R10: nothing moves on the lock side while programming
  p_prog_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prog_mode) |-> ($stable(lock1) && $stable(lock2) && $stable(alarm) && !$rose(tamper)));

  // R6: tamper only starts on a key
  p_tamper_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tamper) |-> $past(key_valid));

endmodule

bind keylock_ctrl keylock_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_valid (key_valid),
  .key_code  (key_code),
  .lock1     (lock1),
  .lock2     (lock2),
  .momentary (momentary),
  .tamper    (tamper),
  .alarm     (alarm),
  .prog_mode (prog_mode)
);

// File: tb/keylock_ctrl_tb_top.sv
module keylock_ctrl_tb_top;
  localparam int E = 40;
  localparam int P = 6;
  localparam logic [3:0] KPROG = 4'hC;
  localparam logic [3:0] KCLR  = 4'hE;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       key_valid;
  logic       key_ready;
  logic [3:0] key_code;
  logic       lock1, lock2, lock_status, momentary, tamper, alarm, prog_mode;

  always #10 clk = ~clk;

  keylock_ctrl #(.ENTRY_CYCLES(E), .PULSE_CYCLES(P)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_valid   (key_valid),
    .key_ready   (key_ready),
    .key_code    (key_code),
    .lock1       (lock1),
    .lock2       (lock2),
    .lock_status (lock_status),
    .momentary   (momentary),
    .tamper      (tamper),
    .alarm       (alarm),
    .prog_mode   (prog_mode)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int now    = 0;

  // reference model state
  int         m_ptr, m_arm, m_pcnt, m_last;
  bit         m_prog, m_l1, m_l2, m_al;
  logic [3:0] m_buf [6];
  logic [3:0] m_head [3];
  logic [3:0] m_p4, m_s4, m_d4;
  int         m_mom_until, m_tam_until;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, now);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic model_reset();
    m_ptr = 0; m_arm = 0; m_pcnt = 0; m_last = 0; m_prog = 0;
    m_l1 = 0; m_l2 = 0; m_al = 0;
    m_head[0] = 4'h0; m_head[1] = 4'h1; m_head[2] = 4'h5;
    m_p4 = 4'h4; m_s4 = 4'h0; m_d4 = 4'h1;
    m_mom_until = -1; m_tam_until = -1;
  endtask

  task automatic model_key(input logic [3:0] k, input int s);
    bit hp, hs, hd;
    if (!m_prog && (m_ptr != 0 || m_arm != 0) && (s - m_last >= E)) begin
      m_ptr = 0; m_arm = 0;
    end
    if (m_prog) begin
      if (k == KCLR) m_pcnt = 0;
      else begin
        m_buf[m_pcnt] = k;
        m_pcnt++;
        if (m_pcnt == 6) begin
          m_head[0] = m_buf[0]; m_head[1] = m_buf[1]; m_head[2] = m_buf[2];
          m_p4 = m_buf[3]; m_s4 = m_buf[4]; m_d4 = m_buf[5];
          m_prog = 0; m_pcnt = 0; m_ptr = 0; m_arm = 0;
        end
      end
      return;
    end
    if (m_arm == 1 && k == KPROG) begin m_arm = 2; m_last = s; return; end
    if (m_arm == 2 && k == KPROG) begin m_arm = 0; m_prog = 1; m_pcnt = 0; return; end
    m_arm = 0;
    if (m_ptr < 3) begin
      if (k == m_head[m_ptr]) begin m_ptr++; m_last = s; end
      else begin m_tam_until = s + P; m_ptr = 0; end
    end else begin
      hp = (k == m_p4);
      hs = (k == m_s4);
      hd = (k == m_d4) && (m_d4 != m_p4);
      m_ptr = 0;
      if (!(hp || hs || hd)) m_tam_until = s + P;
      if (hp || hd) m_l1 = !m_l1;
      if (hs) begin m_l2 = !m_l2; m_arm = 1; m_last = s; end
      if (hd) m_al = 1;
      else if (hp) m_al = 0;
      if (hp) m_mom_until = s + P;
    end
  endtask

  task automatic check_all();
    chk("R3 R5 lock1", lock1, m_l1);
    chk("R4 lock2", lock2, m_l2);
    chk("R5 alarm", alarm, m_al);
    chk("R12 lock_status", lock_status, !m_l1);
    chk("R9 prog_mode", prog_mode, m_prog);
    chk("R6 tamper", tamper, now <= m_tam_until);
    chk("R3 momentary", momentary, now <= m_mom_until);
  endtask

  task automatic press(input logic [3:0] k);
    int s;
    s = now;
    key_valid = 1'b1;
    key_code  = k;
    model_key(k, s);
    tick();
    key_valid = 1'b0;
    key_code  = 4'h0;
    check_all();
  endtask

  task automatic press4(input logic [3:0] a, b, c, d);
    press(a); press(b); press(c); press(d);
  endtask

  task automatic press6(input logic [3:0] a, b, c, d, e, f);
    press(a); press(b); press(c); press(d); press(e); press(f);
  endtask

  function automatic logic [3:0] pick_key();
    int r;
    r = $urandom_range(0, 9);
    if (m_prog) return 4'($urandom_range(0, 15));
    if (r < 6) begin
      if (m_arm != 0) return KPROG;
      if (m_ptr < 3) return m_head[m_ptr];
      case ($urandom_range(0, 2))
        0: return m_p4;
        1: return m_s4;
        default: return m_d4;
      endcase
    end
    if (r < 7) return KPROG;
    return 4'($urandom_range(0, 15));
  endfunction

  function automatic int pick_gap();
    int r;
    r = $urandom_range(0, 19);
    if (r == 0) return E + $urandom_range(0, 5);
    if (r == 1) return E - 1;
    return $urandom_range(1, 3);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", now);
    finish_run();
  end

  initial begin
    int cnt;
    logic l1_before, l2_before;
    void'($urandom(32'd20240611));
    model_reset();
    rst_n     = 1'b0;
    key_valid = 1'b0;
    key_code  = 4'h0;
    idle(3);
    // R1: values during reset
    chk("R1 key_ready in reset", key_ready, 1'b1);
    chk("R1 prog_mode in reset", prog_mode, 1'b0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 lock1", lock1, 1'b0);
    chk("R1 lock2", lock2, 1'b0);
    chk("R1 alarm", alarm, 1'b0);
    chk("R1 tamper", tamper, 1'b0);
    chk("R1 momentary", momentary, 1'b0);
    chk("R1 prog_mode", prog_mode, 1'b0);
    chk("R1 lock_status", lock_status, 1'b1);
    chk("R1 key_ready", key_ready, 1'b1);

    // R2 R3: default primary, momentary width
    press4(4'h0, 4'h1, 4'h5, 4'h4);
    chk("R3 primary toggles lock1", lock1, 1'b1);
    chk("R12 status follows", lock_status, 1'b0);
    cnt = 0;
    while (momentary && cnt < 100) begin cnt++; tick(); end
    chk("R3 momentary width", cnt, P);

    // R4: default secondary
    press4(4'h0, 4'h1, 4'h5, 4'h0);
    chk("R4 secondary toggles lock2", lock2, 1'b1);
    idle(E + 2);

    // R5: default duress
    press4(4'h0, 4'h1, 4'h5, 4'h1);
    chk("R5 duress alarm", alarm, 1'b1);
    chk("R5 duress toggles lock1", lock1, 1'b0);
    idle(3);
    chk("R5 alarm holds", alarm, 1'b1);
    press4(4'h0, 4'h1, 4'h5, 4'h4);
    chk("R3 primary clears alarm", alarm, 1'b0);
    idle(P + 2);

    // R6: mismatch and pointer restart
    press(4'h0); press(4'h1); press(4'h7);
    chk("R6 tamper on wrong digit", tamper, 1'b1);
    press(4'h5);
    chk("R6 pointer restarted", tamper, 1'b1);
    idle(P + 2);
    l1_before = lock1;
    press4(4'h0, 4'h1, 4'h5, 4'h4);
    chk("R6 entry works after tamper", lock1, !l1_before);
    idle(P + 2);

    // R7: timeout boundary
    press(4'h0); press(4'h1);
    idle(E - 1);
    chk("R7 silent expiry", tamper, 1'b0);
    press(4'h5);
    chk("R7 stale sequence dropped", tamper, 1'b1);
    idle(P + 2);
    l1_before = lock1;
    press(4'h0); idle(E - 2); press(4'h1); idle(E - 2); press(4'h5); idle(E - 2); press(4'h4);
    chk("R7 gap just inside window", lock1, !l1_before);
    idle(P + 2);

    // R8: retrigger restarts tamper width
    press(4'h9);
    idle(2);
    press(4'h9);
    cnt = 0;
    while (tamper && cnt < 100) begin cnt++; tick(); end
    chk("R8 tamper restarted", cnt, P);

    // R9: program key after primary is a digit
    press4(4'h0, 4'h1, 4'h5, 4'h4);
    press(KPROG);
    chk("R9 stray program key", tamper, 1'b1);
    chk("R9 stray key no prog", prog_mode, 1'b0);
    idle(P + 2);

    // R9 R10 R11: enter programming, clear midway, capture six
    press4(4'h0, 4'h1, 4'h5, 4'h0);
    press(KPROG); press(KPROG);
    chk("R9 prog_mode raised", prog_mode, 1'b1);
    idle(E + 5);
    chk("R10 no timeout in prog", prog_mode, 1'b1);
    press(4'h3); press(4'h3); press(KCLR);
    chk("R11 clear keeps prog", prog_mode, 1'b1);
    l1_before = lock1; l2_before = lock2;
    press(4'h2); press(4'h6); press(4'h7); press(4'h8); press(4'h9);
    chk("R10 prog holds before sixth", prog_mode, 1'b1);
    chk("R10 locks quiet in prog", {lock1, lock2}, {l1_before, l2_before});
    press(4'hA);
    chk("R10 prog falls on sixth", prog_mode, 1'b0);
    press(4'h0);
    chk("R10 old head rejected", tamper, 1'b1);
    idle(P + 2);
    press4(4'h2, 4'h6, 4'h7, 4'h8);
    chk("R11 new primary after clear", lock1, !l1_before);
    press4(4'h2, 4'h6, 4'h7, 4'hA);
    chk("R10 new duress", alarm, 1'b1);

    // R4: secondary equal to primary
    idle(E + 2);
    press4(4'h2, 4'h6, 4'h7, 4'h9);
    press(KPROG); press(KPROG);
    press6(4'h1, 4'h2, 4'h3, 4'h4, 4'h4, 4'h5);
    l1_before = lock1; l2_before = lock2;
    press4(4'h1, 4'h2, 4'h3, 4'h4);
    chk("R4 shared code lock1", lock1, !l1_before);
    chk("R4 shared code lock2", lock2, !l2_before);

    // R5: duress equal to primary
    press(KPROG); press(KPROG);
    press6(4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h4);
    press4(4'h1, 4'h2, 4'h3, 4'h6);
    press4(4'h1, 4'h2, 4'h3, 4'h5);
    idle(P + 2);
    press4(4'h1, 4'h2, 4'h3, 4'h4);
    chk("R5 equal last digit no alarm", alarm, 1'b0);
    chk("R5 equal last digit is primary", momentary, 1'b1);
    idle(E + 2);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      idle(pick_gap() - 1);
      press(pick_key());
    end

    idle(4);
    finish_run();
  end

endmodule